// File: doc/BRIEF.md
# Shifter Operand Unit

This block forms the second operand of a 32-bit data-processing datapath. A 12-bit operand field selects what happens. One case passes the source register value through. The other cases shift or rotate it by a 5-bit amount carried in the field, or by the low byte of a second register value. The block also produces the shifter carry that a flag-setting instruction would write back. The register file, the ALU and condition evaluation stay outside. The caller supplies the register values it has already read and the address of the current instruction.

The carry result comes on two outputs. The strobe `carry_valid` is high when the shift produced a carry and the instruction asks for flags to be set. When the strobe is low, `carry_out` repeats `carry_in`, so a consumer can always load `carry_out` into its flag. A parameter places an output register after the combinational path. With that register the results follow the inputs by one clock, and a synchronous active-low reset clears them.

Top module: `shifter_operand_unit`

## Requirements
- R1: The operand field decodes as follows. Bits [3:0] are the source index. Bit 4 high selects a register-held amount. Bits [6:5] give the kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. Bits [11:7] hold the immediate amount. When the source index is 15, the value shifted is `pc_val` + 8 in place of `rm_val`.
- R2: An immediate logical left shift by 0 returns the source unchanged and produces no carry.
- R3: A logical left shift by n, for n from 1 to 31 (immediate or register amount), returns the source shifted left by n. Its carry is source bit 32-n.
- R4: An immediate logical or arithmetic right shift encoded with amount 0 shifts by 32. The logical form returns 0 and the arithmetic form returns 32 copies of bit 31. Both carry bit 31.
- R5: A logical right, arithmetic right or rotate right by n, for n from 1 to 31, returns the shifted or rotated source. Its carry is source bit n-1.
- R6: An immediate rotate encoded with amount 0 rotates 33 bits through the carry. The result is {carry_in, source[31:1]} and the carry is source bit 0.
- R7: A register amount uses only bits [7:0] of `rs_val`. When that byte is 0, the source is returned unchanged and no carry is produced.
- R8: A register-amount logical shift (left or right) by 32 or more returns 0. At exactly 32 the carry is bit 0 for the left shift and bit 31 for the right shift. Above 32 the carry is 0.
- R9: A register-amount arithmetic right shift by 32 or more returns 32 copies of bit 31, with carry bit 31.
- R10: A register-amount rotate by a nonzero byte rotates by the byte modulo 32. Its carry is source bit ((byte-1) mod 32).
- R11: `carry_valid` is high only when `set_flags` is high and the operation produced a carry. Whenever `carry_valid` is low, `carry_out` equals `carry_in`.
- R12: With the output register enabled, all three outputs show the result for the inputs at the previous rising clock edge. A clock edge with `rst_n` low clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| op_field | input | 12 | Operand field: source index, kind, register select, amount |
| rm_val | input | 32 | Value read from the source register |
| rs_val | input | 32 | Value read from the amount register; only bits [7:0] are used |
| pc_val | input | 32 | Address of the current instruction |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | Instruction writes flags |
| operand | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry, or carry_in when no carry applies |
| carry_valid | output | 1 | Carry produced and flags requested |

## Verification
The hardest cases to reach are where register amounts leave the 5-bit range. These are amounts of exactly 32, above 32, and nonzero multiples of 32 for the rotate. Each one has its own carry rule, and the low byte of `rs_val` wraps at 256. The stimulus reaches them by sweeping every kind and both amount sources over the amounts 0, 1, 31, 32, 33, 64 and 255. Junk is placed in the upper bits of `rs_val`, and the sweep crosses both carry-in values, both flag settings, three bit patterns and the source index 15.

// File: rtl/shifter_operand_pkg.sv
// Shared types for the shifter operand unit.
package shifter_operand_pkg;

    // Operation kind, as encoded in op_field[6:5].
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    // Decoded control for the shift datapath.
    typedef struct packed {
        shift_kind_e kind;
        logic        rrx;     // rotate one place through carry
        logic        bypass;  // pass through, no carry produced
    } shift_ctl_t;

endpackage

// File: rtl/shifter_amount_decode.sv
// Decodes the kind and the effective amount from the upper operand field.
// Assumes op_hi = op_field[11:4].
// Zero encodings are folded here:
//   immediate LSL #0 is a pass-through,
//   immediate LSR/ASR #0 becomes a shift by DATA_W,
//   immediate ROR #0 becomes RRX,
//   a zero register byte is a pass-through.
module shifter_amount_decode
    import shifter_operand_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RSB_W  = 8,
    parameter int AMT_W  = 8
) (
    input  logic [7:0]       op_hi,
    input  logic [RSB_W-1:0] rs_byte,
    output shift_ctl_t       ctl,
    output logic [AMT_W-1:0] amount
);
    localparam int IMM_W = 5;

    logic [IMM_W-1:0] imm;
    logic             is_reg;

    assign imm    = op_hi[7:3];
    assign is_reg = op_hi[0];

    // Select the amount source and reinterpret zero encodings.
    always_comb begin
        ctl.kind   = shift_kind_e'(op_hi[2:1]);
        ctl.rrx    = 1'b0;
        ctl.bypass = 1'b0;
        amount     = '0;
        if (is_reg) begin
            amount     = AMT_W'(rs_byte);
            ctl.bypass = (rs_byte == '0);
        end else if (imm == '0) begin
            unique case (ctl.kind)
                SK_LSL:         ctl.bypass = 1'b1;
                SK_LSR, SK_ASR: amount     = AMT_W'(DATA_W);
                SK_ROR:         ctl.rrx    = 1'b1;
                default:        ctl.bypass = 1'b1;
            endcase
        end else begin
            amount = AMT_W'(imm);
        end
    end
endmodule

// File: rtl/shifter_core.sv
// Shift/rotate datapath with carry generation.
// Assumes the amount was already decoded: bypass and rrx take precedence,
// and the amount is never zero otherwise.
module shifter_core
    import shifter_operand_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  shift_ctl_t        ctl,
    input  logic [AMT_W-1:0]  amount,
    input  logic [DATA_W-1:0] src,
    input  logic              cin,
    output logic [DATA_W-1:0] result,
    output logic              cout,
    output logic              produced
);
    localparam int ROT_W = $clog2(DATA_W);

    logic                      over;     // amount strictly above DATA_W
    logic [AMT_W-1:0]          asr_amt;  // amount saturated at DATA_W
    logic [DATA_W:0]           lsl_w;
    logic [DATA_W:0]           lsr_w;
    logic signed [DATA_W:0]    asr_w;
    logic [2*DATA_W-1:0]       ror_w;

    assign over    = int'(amount) > DATA_W;
    assign asr_amt = over ? AMT_W'(DATA_W) : amount;
    assign lsl_w   = {1'b0, src} << amount;
    assign lsr_w   = {src, 1'b0} >> amount;
    assign asr_w   = $signed({src, 1'b0}) >>> asr_amt;
    assign ror_w   = {src, src} >> amount[ROT_W-1:0];

    // Pick the result and carry for the decoded operation.
    always_comb begin
        result   = src;
        cout     = cin;
        produced = 1'b1;
        if (ctl.bypass) begin
            produced = 1'b0;
        end else if (ctl.rrx) begin
            result = {cin, src[DATA_W-1:1]};
            cout   = src[0];
        end else begin
            unique case (ctl.kind)
                SK_LSL: begin
                    result = over ? '0 : lsl_w[DATA_W-1:0];
                    cout   = over ? 1'b0 : lsl_w[DATA_W];
                end
                SK_LSR: begin
                    result = over ? '0 : lsr_w[DATA_W:1];
                    cout   = over ? 1'b0 : lsr_w[0];
                end
                SK_ASR: begin
                    result = asr_w[DATA_W:1];
                    cout   = asr_w[0];
                end
                default: begin
                    result = ror_w[DATA_W-1:0];
                    cout   = ror_w[DATA_W-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/shifter_operand_unit.sv
// Top of the shifter operand unit. It selects the source (the register value,
// or pc+PC_OFFSET for index 15), decodes the field, shifts, and gates the
// carry with set_flags. REG_OUT=1 adds an output register with a synchronous
// active-low reset.
module shifter_operand_unit
    import shifter_operand_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RSB_W     = 8,
    parameter int PC_OFFSET = 8,
    parameter bit REG_OUT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       op_field,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] pc_val,
    input  logic              carry_in,
    input  logic              set_flags,
    output logic [DATA_W-1:0] operand,
    output logic              carry_out,
    output logic              carry_valid
);
    localparam int AMT_W  = (RSB_W > $clog2(DATA_W) + 1) ? RSB_W : $clog2(DATA_W) + 1;
    localparam logic [3:0] PC_IDX = 4'hF;

    logic [DATA_W-1:0] src;
    shift_ctl_t        ctl;
    logic [AMT_W-1:0]  amount;
    logic [DATA_W-1:0] res;
    logic              c_raw;
    logic              produced;
    logic [DATA_W-1:0] nxt_op;
    logic              nxt_co;
    logic              nxt_cv;
    logic              rs_hi_unused;

    assign rs_hi_unused = ^rs_val[DATA_W-1:RSB_W];

    // Source select: index 15 reads the pipeline-adjusted instruction address.
    assign src = (op_field[3:0] == PC_IDX) ? pc_val + DATA_W'(PC_OFFSET) : rm_val;

    shifter_amount_decode #(
        .DATA_W (DATA_W),
        .RSB_W  (RSB_W),
        .AMT_W  (AMT_W)
    ) u_dec (
        .op_hi   (op_field[11:4]),
        .rs_byte (rs_val[RSB_W-1:0]),
        .ctl     (ctl),
        .amount  (amount)
    );

    shifter_core #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_core (
        .ctl      (ctl),
        .amount   (amount),
        .src      (src),
        .cin      (carry_in),
        .result   (res),
        .cout     (c_raw),
        .produced (produced)
    );

    // Flag gating: the carry is reported only for flag-setting operations.
    assign nxt_op = res;
    assign nxt_cv = set_flags & produced;
    assign nxt_co = nxt_cv ? c_raw : carry_in;

    generate
        if (REG_OUT) begin : g_reg
            // Output register, cleared by a synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    operand     <= '0;
                    carry_out   <= 1'b0;
                    carry_valid <= 1'b0;
                end else begin
                    operand     <= nxt_op;
                    carry_out   <= nxt_co;
                    carry_valid <= nxt_cv;
                end
            end
        end else begin : g_comb
            logic clk_unused;
            assign clk_unused  = clk ^ rst_n;
            assign operand     = nxt_op;
            assign carry_out   = nxt_co;
            assign carry_valid = nxt_cv;
        end
    endgenerate
endmodule

// File: rtl/shifter_operand_unit_chk.sv
// Property checker for shifter_operand_unit. It realigns the inputs to the
// output timing: it registers them when REG_OUT=1 and passes them straight
// through otherwise.
module shifter_operand_unit_chk #(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [11:0]       op_field,
    input logic [DATA_W-1:0] rm_val,
    input logic [7:0]        rs_byte,
    input logic [DATA_W-1:0] pc_val,
    input logic              carry_in,
    input logic              set_flags,
    input logic [DATA_W-1:0] operand,
    input logic              carry_out,
    input logic              carry_valid
);
    logic [11:0]       s_fld;
    logic [DATA_W-1:0] s_rm;
    logic [7:0]        s_rs;
    logic [DATA_W-1:0] s_pc;
    logic              s_cin;
    logic              s_sf;

    generate
        if (REG_OUT) begin : g_align
            // Hold the inputs one cycle so they line up with the outputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_fld <= '0; s_rm <= '0; s_rs <= '0;
                    s_pc  <= '0; s_cin <= 1'b0; s_sf <= 1'b0;
                end else begin
                    s_fld <= op_field; s_rm <= rm_val; s_rs <= rs_byte;
                    s_pc  <= pc_val; s_cin <= carry_in; s_sf <= set_flags;
                end
            end
        end else begin : g_direct
            // The outputs are combinational, so the inputs are used as they are.
            always_comb begin
                s_fld = op_field; s_rm = rm_val; s_rs = rs_byte;
                s_pc  = pc_val; s_cin = carry_in; s_sf = set_flags;
            end
        end
    endgenerate

    p_pc_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_fld[3:0] == 4'hF && s_fld[6:4] == 3'b000 && s_fld[11:7] == 5'd0)
        |-> operand == s_pc + DATA_W'(8));

    p_lsl_zero_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_fld[3:0] != 4'hF && s_fld[6:4] == 3'b000 && s_fld[11:7] == 5'd0)
        |-> (operand == s_rm && !carry_valid));

    p_rrx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_fld[3:0] != 4'hF && s_fld[6:4] == 3'b110 && s_fld[11:7] == 5'd0)
        |-> (operand == {s_cin, s_rm[DATA_W-1:1]} && carry_out == (s_sf ? s_rm[0] : s_cin)));

    p_reg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_fld[3:0] != 4'hF && s_fld[4] && s_rs == 8'd0)
        |-> (operand == s_rm && !carry_valid));

    p_lsl_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_fld[6:4] == 3'b001 && s_rs > 8'd32) |-> (operand == '0 && !(carry_valid && carry_out)));

    p_flag_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !s_sf |-> !carry_valid);

    p_carry_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_valid |-> carry_out == s_cin);
endmodule

bind shifter_operand_unit shifter_operand_unit_chk #(
    .DATA_W  (DATA_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_field    (op_field),
    .rm_val      (rm_val),
    .rs_byte     (rs_val[7:0]),
    .pc_val      (pc_val),
    .carry_in    (carry_in),
    .set_flags   (set_flags),
    .operand     (operand),
    .carry_out   (carry_out),
    .carry_valid (carry_valid)
);

// File: tb/tb_shifter_operand_unit.sv
// Sweeps every kind, both amount sources, the edge amounts, both carry-ins,
// both flag settings, three patterns and source index 15. The expected values
// come from the requirements.
module tb_shifter_operand_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] op_field;
    logic [31:0] rm_val, rs_val, pc_val;
    logic        carry_in, set_flags;
    logic [31:0] operand;
    logic        carry_out, carry_valid;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shifter_operand_unit #(.REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .op_field(op_field), .rm_val(rm_val),
        .rs_val(rs_val), .pc_val(pc_val), .carry_in(carry_in),
        .set_flags(set_flags), .operand(operand), .carry_out(carry_out),
        .carry_valid(carry_valid)
    );

    // Arithmetic model of the requirements.
    task automatic model(input logic [11:0] f, input logic [31:0] rm, input logic [31:0] rs,
                         input logic [31:0] pc, input bit cin, input bit sf,
                         output logic [31:0] e_op, output bit e_co, output bit e_cv,
                         output string tag);
        logic [31:0] x;
        int  k, n, r;
        bit  isreg, has, c;
        x     = (f[3:0] == 4'hF) ? pc + 32'd8 : rm;           // R1
        k     = int'(f[6:5]);
        isreg = f[4];
        n     = isreg ? int'(rs[7:0]) : int'(f[11:7]);
        has   = 1'b1; c = 1'b0; e_op = x; tag = "R5";
        if (isreg && n == 0) begin
            has = 1'b0; tag = "R7";
        end else begin
            case (k)
                0: if (!isreg && n == 0) begin has = 1'b0; tag = "R2"; end
                   else if (n < 32) begin e_op = x << n; c = x[32-n]; tag = "R3"; end
                   else begin e_op = 0; c = (n == 32) ? x[0] : 1'b0; tag = "R8"; end
                1: begin
                       if (!isreg && n == 0) begin n = 32; tag = "R4"; end
                       if (n < 32) begin e_op = x >> n; c = x[n-1]; end
                       else begin e_op = 0; c = (n == 32) ? x[31] : 1'b0; if (isreg) tag = "R8"; end
                   end
                2: begin
                       if (!isreg && n == 0) begin n = 32; tag = "R4"; end
                       if (n < 32) begin e_op = 32'($signed(x) >>> n); c = x[n-1]; end
                       else begin e_op = {32{x[31]}}; c = x[31]; if (isreg) tag = "R9"; end
                   end
                default:
                   if (!isreg && n == 0) begin e_op = {cin, x[31:1]}; c = x[0]; tag = "R6"; end
                   else begin
                       r = n % 32;
                       if (isreg) tag = "R10";
                       if (r == 0) begin e_op = x; c = x[31]; end
                       else begin e_op = (x >> r) | (x << (32 - r)); c = x[r-1]; end
                   end
            endcase
        end
        e_cv = sf && has;                                    // R11
        e_co = e_cv ? c : cin;
        if (!sf) tag = {tag, "/R11"};
        if (f[3:0] == 4'hF) tag = {tag, "/R1"};
    endtask

    task automatic compare(input string tag, input logic [31:0] e_op, input bit e_co, input bit e_cv);
        n_chk++;
        if (operand !== e_op || carry_out !== e_co || carry_valid !== e_cv) begin
            n_bad++;
            $display("FAIL %s field=%h: got op=%h co=%b cv=%b, expected op=%h co=%b cv=%b",
                     tag, op_field, operand, carry_out, carry_valid, e_op, e_co, e_cv);
        end
    endtask

    // Apply one vector at the falling edge and compare one clock later (R12).
    task automatic run_one(input logic [11:0] f, input logic [31:0] rm, input logic [31:0] rs,
                           input bit cin, input bit sf);
        logic [31:0] e_op;
        bit e_co, e_cv;
        string tag;
        @(negedge clk);
        op_field = f; rm_val = rm; rs_val = rs; carry_in = cin; set_flags = sf;
        model(f, rm, rs, pc_val, cin, sf, e_op, e_co, e_cv, tag);
        @(posedge clk);
        #1;
        compare(tag, e_op, e_co, e_cv);
    endtask

    initial begin
        automatic int amts [7] = '{0, 1, 31, 32, 33, 64, 255};
        automatic logic [31:0] pats [3] = '{32'h8000_0001, 32'h7F0F_1235, 32'hFFFF_FFFE};
        rst_n = 1'b0; op_field = 12'h0F3; rm_val = 32'hDEAD_BEEF; rs_val = 32'h20;
        pc_val = 32'h0000_1F00; carry_in = 1'b1; set_flags = 1'b1;
        // R12: the reset clears all outputs even with live inputs.
        repeat (3) @(posedge clk);
        #1;
        compare("R12 reset", 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++)
            for (int isreg = 0; isreg < 2; isreg++)
                for (int a = 0; a < 7; a++)
                    for (int p = 0; p < 3; p++)
                        for (int ix = 0; ix < 2; ix++)
                            for (int cin = 0; cin < 2; cin++)
                                for (int sf = 0; sf < 2; sf++) begin
                                    logic [11:0] f;
                                    logic [3:0]  idx;
                                    idx = (ix == 1) ? 4'hF : 4'h3;
                                    if (isreg != 0)
                                        f = {4'h2, 1'b0, 2'(k), 1'b1, idx};
                                    else
                                        f = {5'(amts[a]), 2'(k), 1'b0, idx};
                                    // Junk in rs_val[31:8] checks that only the low byte counts (R7).
                                    run_one(f, pats[p], {24'hC3A5_5A, 8'(amts[a])}, cin[0], sf[0]);
                                end
        // R12: a change in the inputs appears on the outputs only after the next edge.
        @(negedge clk);
        op_field = 12'h000; rm_val = 32'h1234_5678; set_flags = 1'b0; carry_in = 1'b0;
        #1;
        n_chk++;
        if (operand === 32'h1234_5678) begin
            n_bad++;
            $display("FAIL R12 latency: got op=%h, expected previous value", operand);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule